// File: doc/BRIEF.md
# Serial SAR Converter Start-Line Sequencer

This block runs a serial successive-approximation converter that is controlled by one convert-start line, from the host side. When a request arrives, the block raises the start line so that the converter powers up and tracks its input. It keeps the line high for the acquisition window and then lowers it, which freezes the sample and starts the conversion. It waits out the conversion delay and then clocks in the 12-bit result, most significant bit first. The result comes out on a parallel bus with a one-cycle valid strobe.

The converter chooses its input channel from how the previous readout ended. If all twelve bits were clocked out before the start line rose again, the next sample comes from channel 1. If the readout was cut short, the next sample comes from channel 2. To take a channel-2 sample, the block first runs a throw-away conversion with a short readout. It then starts a second acquisition, which the converter takes on channel 2. Every real readout is complete, so the converter always returns to channel 1 afterwards. All delays are parameters in nanoseconds, turned into system-clock cycles from a clock-rate parameter.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the start line, the serial clock and the valid strobe are all low.
- R2: A request accepted while idle raises the start line on the next cycle. The line stays high for exactly ACQ cycles, where ACQ is the acquisition time in ns multiplied by the clock rate and rounded up (150 cycles for 1500 ns at 100 MHz).
- R3: A programmed acquisition time below 1400 ns is raised to 1400 ns (140 cycles at 100 MHz).
- R4: After the start line falls, the serial clock makes its first rising edge exactly CONV plus HALF cycles later. CONV is the 3700 ns conversion delay, 370 cycles. HALF is the serial half period, 5 cycles.
- R5: The serial clock idles low and toggles every HALF cycles, starting with a low phase. The data input is sampled on each rising edge, and the first bit sampled is the most significant.
- R6: After the twelfth rising edge come HALF low cycles and one quiet cycle. Then the valid strobe is high for exactly one cycle. It comes with the 12-bit word and a channel tag: 0 for channel 1, 1 for channel 2.
- R7: A request with the channel input at 1 first runs a conversion read out with only ABORT_BITS clocks (11 by default, always fewer than 12). That conversion gives no valid strobe. One quiet cycle follows, then a new acquisition, and that sample, taken on channel 2, is read in full.
- R8: A request made while a sequence is running is ignored. It does not change the waveform and does not produce an extra result.
- R9: Synchronous reset in the middle of a sequence drives the start line and the serial clock low on the next cycle, and the block then stays idle.
- R10: A channel-1 request made after a channel-2 result is sampled on channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request one conversion (taken only when idle) |
| chan_req | input | 1 | Channel wanted: 0 = channel 1, 1 = channel 2 |
| cnvst_o | output | 1 | Convert-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| result_o | output | RES_W (12) | Last result word |
| result_ch_o | output | 1 | Channel of the last result: 0 = channel 1, 1 = channel 2 |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench includes a behavioural converter. The converter picks its channel from the count of clocks in the previous readout, and it drives inverted data until 3.7 µs after the fall. A controller that clocks too early therefore reads a complemented word. A controller that reads only part of the word therefore gets a channel-2 sample where channel 1 was wanted. Channel-2 requests, back-to-back requests, and requests made while busy test that the short readout gives no result and that a request is never taken twice. A second instance with a very short programmed acquisition time exposes a missing clamp through the width of its start pulse. A reset during the conversion wait checks that the block goes quiet.

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int CLK_KHZ      = 100_000,
  parameter int ACQ_NS       = 1500,
  parameter int CONV_NS      = 3700,
  parameter int SCLK_HALF_NS = 50,
  parameter int ABORT_BITS   = 11,
  parameter int RES_W        = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             chan_req,
  output logic             cnvst_o,
  output logic             sclk_o,
  input  logic             sdata_i,
  output logic [RES_W-1:0] result_o,
  output logic             result_ch_o,
  output logic             result_valid_o
);

  function automatic int ns2cyc(input int ns);
    longint prod;
    prod = longint'(ns) * longint'(CLK_KHZ);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  localparam int MIN_ACQ_NS = 1400;
  localparam int ACQ_EFF_NS = (ACQ_NS < MIN_ACQ_NS) ? MIN_ACQ_NS : ACQ_NS;
  localparam int ACQ_CYC    = ns2cyc(ACQ_EFF_NS);
  localparam int CONV_RAW   = ns2cyc(CONV_NS);
  localparam int CONV_CYC   = (CONV_RAW < 1) ? 1 : CONV_RAW;
  localparam int HALF_RAW   = ns2cyc(SCLK_HALF_NS);
  localparam int HALF_CYC   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int MAX_A      = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int MAX_CYC    = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);
  localparam int BW         = $clog2(RES_W + 1);
  localparam int ABORT_LIM  = (ABORT_BITS >= RES_W) ? RES_W - 1 :
                              (ABORT_BITS < 0) ? 0 : ABORT_BITS;

  typedef enum logic [2:0] {
    S_IDLE, S_ACQ, S_CONV, S_SHIFT, S_DONE, S_ABORT
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbits;
  logic [RES_W-1:0] sh;
  logic [RES_W-1:0] res_q;
  logic             cnvst_q, sclk_q, full_q, ch_q, vld_q;

  wire              cnt_zero = (cnt == '0);
  wire [BW-1:0]     lim      = full_q ? BW'(RES_W) : BW'(ABORT_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbits   <= '0;
      sh      <= '0;
      res_q   <= '0;
      cnvst_q <= 1'b0;
      sclk_q  <= 1'b0;
      full_q  <= 1'b0;
      ch_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start_req) begin
            cnvst_q <= 1'b1;
            cnt     <= CW'(ACQ_CYC - 1);
            ch_q    <= chan_req;
            full_q  <= ~chan_req;
            st      <= S_ACQ;
          end
        S_ACQ:
          if (cnt_zero) begin
            cnvst_q <= 1'b0;
            cnt     <= CW'(CONV_CYC - 1);
            st      <= S_CONV;
          end else cnt <= cnt - 1'b1;
        S_CONV:
          if (cnt_zero) begin
            cnt   <= CW'(HALF_CYC - 1);
            nbits <= '0;
            st    <= S_SHIFT;
          end else cnt <= cnt - 1'b1;
        S_SHIFT:
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (sclk_q) begin
            sclk_q <= 1'b0;
            cnt    <= CW'(HALF_CYC - 1);
          end else if (nbits == lim) begin
            st <= full_q ? S_DONE : S_ABORT;
          end else begin
            sclk_q <= 1'b1;
            sh     <= {sh[RES_W-2:0], sdata_i};
            nbits  <= nbits + 1'b1;
            cnt    <= CW'(HALF_CYC - 1);
          end
        S_DONE: begin
          res_q <= sh;
          vld_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_ABORT: begin
          cnvst_q <= 1'b1;
          cnt     <= CW'(ACQ_CYC - 1);
          full_q  <= 1'b1;
          st      <= S_ACQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cnvst_o        = cnvst_q;
  assign sclk_o         = sclk_q;
  assign result_o       = res_q;
  assign result_ch_o    = ch_q;
  assign result_valid_o = vld_q;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int CLK_KHZ = 100_000,
  parameter int CONV_NS = 3700,
  parameter int RES_W   = 12
) (
  input logic clk,
  input logic rst,
  input logic cnvst_o,
  input logic sclk_o,
  input logic result_valid_o
);

  localparam longint MIN_P  = longint'(1400) * longint'(CLK_KHZ);
  localparam int     MIN_C  = int'((MIN_P + 64'd999_999) / 64'd1_000_000);
  localparam longint CONV_P = longint'(CONV_NS) * longint'(CLK_KHZ);
  localparam int     CONV_C = int'((CONV_P + 64'd999_999) / 64'd1_000_000);
  localparam int     SAT    = 1 << 30;

  int   hi_cnt, lo_cnt, rise_cnt;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= 0;
      lo_cnt   <= 0;
      rise_cnt <= 0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      hi_cnt <= cnvst_o ? ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt <= cnvst_o ? 0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
      if (cnvst_o) rise_cnt <= 0;
      else if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + 1;
    end
  end

  assert_quiet_after_reset_R9: assert property (@(posedge clk)
    rst |=> (!cnvst_o && !sclk_o && !result_valid_o));

  assert_acq_floor_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cnvst_o) |-> (hi_cnt >= MIN_C));

  assert_conv_wait_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (lo_cnt >= CONV_C));

  assert_sclk_low_in_track_R5: assert property (@(posedge clk) disable iff (rst)
    cnvst_o |-> !sclk_o);

  assert_no_extra_bits_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cnvst_o) |-> (rise_cnt <= RES_W));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  assert_valid_after_full_read_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (!cnvst_o && !sclk_o && rise_cnt == RES_W));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
  .CLK_KHZ(CLK_KHZ),
  .CONV_NS(CONV_NS),
  .RES_W(RES_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .cnvst_o(cnvst_o),
  .sclk_o(sclk_o),
  .result_valid_o(result_valid_o)
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;

  localparam int ACQ_C   = 150;
  localparam int MIN_C   = 140;
  localparam int CONV_C  = 370;
  localparam int HALF_C  = 5;
  localparam int ABORT_N = 11;

  logic clk = 1'b0, rst = 1'b1, start_req = 1'b0, chan_req = 1'b0, sdata = 1'b0;
  logic cnvst, sclk, vld, res_ch;
  logic [11:0] result;
  logic start_m = 1'b0;
  logic cnvst_m, sclk_m, vld_m, ch_m;
  logic [11:0] result_m;

  always #5 clk = ~clk;

  sar_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .chan_req(chan_req),
    .cnvst_o(cnvst), .sclk_o(sclk), .sdata_i(sdata),
    .result_o(result), .result_ch_o(res_ch), .result_valid_o(vld));

  sar_seq_ctrl #(.ACQ_NS(300)) u_dut_min (
    .clk(clk), .rst(rst), .start_req(start_m), .chan_req(1'b0),
    .cnvst_o(cnvst_m), .sclk_o(sclk_m), .sdata_i(1'b0),
    .result_o(result_m), .result_ch_o(ch_m), .result_valid_o(vld_m));

  int checks = 0, errors = 0;
  int cyc = 0, nvalid = 0, nconv = 0;
  logic [2:0] expq[$];
  int reqq[$];
  logic [2:0] e;
  bit started = 0, fresh = 1;
  logic pc = 0, ps = 0;
  int rise_cyc = 0, fall_cyc = -100000, rises = 0, bidx = 12;
  int cur_ch = 1, conv_ch = 1;
  logic [11:0] word = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_pass(input int nb, input bit full);
    repeat (ACQ_C) expq.push_back(3'b100);
    repeat (CONV_C + HALF_C) expq.push_back(3'b000);
    repeat (nb) begin
      repeat (HALF_C) expq.push_back(3'b010);
      repeat (HALF_C) expq.push_back(3'b000);
    end
    expq.push_back(3'b000);
    if (full) expq.push_back(3'b001);
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      expq.delete();
      reqq.delete();
    end else if (expq.size() == 0 && start_req) begin
      if (!chan_req) push_pass(12, 1'b1);
      else begin
        push_pass(ABORT_N, 1'b0);
        push_pass(12, 1'b1);
      end
      reqq.push_back(chan_req ? 1 : 0);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      e = (expq.size() > 0) ? expq.pop_front() : 3'b000;
      checks++;
      if ({cnvst, sclk, vld} !== e) begin
        errors++;
        $display("FAIL %s cycle %0d: cnvst/sclk/valid got %b%b%b expected %b",
                 (cnvst !== e[2]) ? "R2" : (sclk !== e[1]) ? "R5" : "R6",
                 cyc, cnvst, sclk, vld, e);
      end
    end
    if (cnvst && !pc) begin
      cur_ch = (fresh || rises >= 12) ? 1 : 2;
      fresh = 0;
      rise_cyc = cyc;
    end
    if (!cnvst && pc) begin
      chk(cyc - rise_cyc == ACQ_C, "R2", "start line high cycles", cyc - rise_cyc, ACQ_C);
      nconv++;
      word = (cur_ch == 1) ? (12'hA5C ^ 12'(nconv * 291)) : (12'h3B7 + 12'(nconv * 37));
      conv_ch = cur_ch;
      fall_cyc = cyc;
      rises = 0;
      bidx = 0;
    end
    if (sclk && !ps) begin
      if (rises == 0)
        chk(cyc - fall_cyc == CONV_C + HALF_C, "R4", "fall to first clock", cyc - fall_cyc,
            CONV_C + HALF_C);
      rises++;
    end
    if (!sclk && ps) bidx++;
    sdata = (bidx < 12) ? word[11 - bidx] : 1'b0;
    if (cyc - fall_cyc < CONV_C) sdata = ~sdata;
    pc = cnvst;
    ps = sclk;
    if (vld && !rst) begin
      int r;
      nvalid++;
      r = (reqq.size() > 0) ? reqq.pop_front() : -1;
      chk(result == word, "R5 R6", "result word MSB first", int'(result), int'(word));
      chk(int'(res_ch) == r, "R6", "channel tag", int'(res_ch), r);
      if (r == 1) chk(conv_ch == 2, "R7", "converter channel", conv_ch, 2);
      else        chk(conv_ch == 1, "R10", "converter channel", conv_ch, 1);
    end
  end

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_req(input bit ch);
    @(negedge clk);
    start_req = 1'b1;
    chan_req = ch;
    @(negedge clk);
    start_req = 1'b0;
    wait_idle();
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, hl;
    repeat (5) @(negedge clk);
    chk({cnvst, sclk, vld} == 3'b000, "R1", "outputs in reset", int'({cnvst, sclk, vld}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cnvst, sclk, vld, cnvst_m} == 4'b0000, "R1", "outputs after reset",
        int'({cnvst, sclk, vld, cnvst_m}), 0);

    start_m = 1'b1;
    @(negedge clk);
    start_m = 1'b0;
    hl = 0;
    while (!cnvst_m) @(negedge clk);
    while (cnvst_m) begin hl++; @(negedge clk); end
    chk(hl == MIN_C, "R3", "clamped acquisition cycles", hl, MIN_C);

    do_req(1'b0);
    do_req(1'b1);
    do_req(1'b0);
    do_req(1'b1);
    do_req(1'b1);
    do_req(1'b0);

    n0 = nvalid;
    @(negedge clk);
    start_req = 1'b1;
    chan_req = 1'b0;
    @(negedge clk);
    start_req = 1'b0;
    repeat (300) @(negedge clk);
    start_req = 1'b1;
    chan_req = 1'b1;
    repeat (3) @(negedge clk);
    start_req = 1'b0;
    repeat (200) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    wait_idle();
    chk(nvalid == n0 + 1, "R8", "results from busy requests", nvalid - n0, 1);

    n0 = nvalid;
    @(negedge clk);
    start_req = 1'b1;
    chan_req = 1'b0;
    while (!vld) @(negedge clk);
    chan_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    wait_idle();
    chk(nvalid == n0 + 2, "R8", "back-to-back results", nvalid - n0, 2);

    @(negedge clk);
    start_req = 1'b1;
    chan_req = 1'b0;
    @(negedge clk);
    start_req = 1'b0;
    repeat (250) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({cnvst, sclk, vld} == 3'b000, "R9", "outputs after mid reset", int'({cnvst, sclk, vld}), 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk({cnvst, sclk, vld} == 3'b000, "R9", "idle after mid reset", int'({cnvst, sclk, vld}), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule